// File: doc/BRIEF.md
# Boot Reset Sequencer with Address-Mode Strap

This block sits between the board-level reset pin and a processor core. The pin may move at any moment relative to the clock. Its low level pulls the core into reset at once and clears every piece of sequencing state. Its rising edge is aligned to the clock through a short chain of flops before the core is released. Once the core is out of reset, a countdown in half-clock steps times the first instruction fetch. A one-period strobe starts on the falling clock edge six and a half periods after the synchronized release. While the strobe is high, it carries the 20-bit restart address 20'hFFFF0.

Early in the same release window, the block latches an address-mode strap and holds it until the next reset. The latched strap decides whether the disable-address bit of the upper and lower memory region controls is honoured. The resulting flag tells the bus unit to leave the address off the multiplexed lines during the address phase. The address then appears only on the dedicated address pins.

Top module: `boot_reset_seq`

## Requirements
- R1: While `rst_in_n` is low, `core_rst_n`, `fetch_go` and `seq_half` are 0 and `strap_q` is 1, and a falling `rst_in_n` forces this at once, without waiting for a clock edge.
- R2: After `rst_in_n` rises between clock edges, `core_rst_n` goes high on the second rising edge that follows. It stays high until `rst_in_n` falls again.
- R3: `seq_half` counts clock edges of both polarities after the rising edge where `core_rst_n` went high. It reads 1 after the first falling edge and stops at 13.
- R4: `fetch_go` rises on the falling edge where `seq_half` reaches 13, stays high for exactly one clock period, and pulses only once per reset.
- R5: `fetch_addr` equals 20'hFFFF0 while `fetch_go` is high and 0 otherwise.
- R6: A reset during the countdown returns `seq_half` to 0 and removes any pending strobe. The next release times the fetch again from the beginning.
- R7: `strap_in` is captured into `strap_q` on the first rising edge after the edge where `core_rst_n` rose. Later changes of `strap_in` do not affect `strap_q` until the next reset.
- R8: `region_sel` uses the encoding 2'b01 = lower region and 2'b10 = upper region. With `strap_q` high, `addr_omit` equals bit 7 of `lower_ctl` or of `upper_ctl` for the selected region.
- R9: With `strap_q` low, `addr_omit` is 0 whatever either control byte holds.
- R10: With `region_sel` at 2'b00 or 2'b11, `addr_omit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; both edges used |
| rst_in_n | input | 1 | Board reset, active low, asynchronous |
| strap_in | input | 1 | Address-mode strap (board pull-up keeps it high by default) |
| region_sel | input | 2 | Region of the current bus cycle: 01 lower, 10 upper, else none |
| upper_ctl | input | 8 | Upper region control byte; bit 7 disables the address phase |
| lower_ctl | input | 8 | Lower region control byte; bit 7 disables the address phase |
| core_rst_n | output | 1 | Synchronized core reset, active low |
| fetch_go | output | 1 | One-period strobe that starts instruction fetch |
| fetch_addr | output | 20 | Restart address while `fetch_go` is high, else 0 |
| seq_half | output | 4 | Half-period counter since release, stops at 13 |
| strap_q | output | 1 | Latched strap |
| addr_omit | output | 1 | Leave the address off the multiplexed bus |

## Verification
`core_rst_n` is due two rising edges after a release and drops at the moment reset is asserted. `seq_half` moves on every edge after that. `fetch_go` is due on the falling edge 6.5 periods later, and `strap_q` one rising edge after release. `addr_omit` follows its inputs within the same cycle. Inputs change 2 ns after a rising edge. The behavioural model advances on the same edges, and all outputs are compared with it 5 ns after every rising and every falling edge. Each comparison therefore sees results that are settled and already due.

// File: rtl/boot_reset_pkg.sv
package boot_reset_pkg;

    // Region code of the current bus cycle
    typedef enum logic [1:0] {
        RGN_NONE  = 2'b00,
        RGN_LOWER = 2'b01,
        RGN_UPPER = 2'b10,
        RGN_SPARE = 2'b11
    } region_e;

    localparam int unsigned ADDR_W      = 20;
    localparam int unsigned CTL_W       = 8;
    localparam int unsigned DIS_BIT     = 7;
    localparam logic [ADDR_W-1:0] RESTART_VEC = 20'hFFFF0;

endpackage

// File: rtl/boot_reset_sync.sv
// Reset release synchronizer.
// Does: drops the core reset the moment the board reset falls, and
// raises it only after STAGES rising edges with the board reset high.
// Assumes: STAGES >= 2; board reset may change at any time.
module boot_reset_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic core_rst_n
);

    logic [STAGES-1:0] stg;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage: captures a constant high once reset is released
                always_ff @(posedge clk or negedge rst_in_n) begin
                    if (!rst_in_n) stg[0] <= 1'b0;
                    else           stg[0] <= 1'b1;
                end
            end else begin : g_next
                // Later stages: shift the release along the chain
                always_ff @(posedge clk or negedge rst_in_n) begin
                    if (!rst_in_n) stg[gi] <= 1'b0;
                    else           stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign core_rst_n = stg[STAGES-1];

    AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_in_n)
        core_rst_n |=> core_rst_n); // R2

endmodule

// File: rtl/boot_reset_timer.sv
// Fetch start timer.
// Does: counts whole periods on rising edges and half periods on falling
// edges after core release; raises a one-period fetch strobe on the
// falling edge FULL+0.5 periods after release.
// Assumes: core_rst_n comes from the synchronizer and is low whenever
// rst_in_n is low.
module boot_reset_timer #(
    parameter int unsigned FULL = 6,
    localparam int unsigned PW  = $clog2(FULL + 2),
    localparam int unsigned HW  = $clog2(2 * FULL + 2)
) (
    input  logic          clk,
    input  logic          rst_in_n,
    input  logic          core_rst_n,
    output logic          go,
    output logic [HW-1:0] half
);

    localparam logic [PW-1:0] FULL_P = PW'(FULL);
    localparam logic [PW-1:0] NEGMAX = PW'(FULL + 1);
    localparam logic [HW-1:0] TERM   = HW'(2 * FULL + 1);

    logic [PW-1:0] pos_cnt;
    logic [PW-1:0] neg_cnt;

    // Whole periods seen since release, stopping at FULL
    always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n)                        pos_cnt <= '0;
        else if (!core_rst_n)                 pos_cnt <= '0;
        else if (pos_cnt < FULL_P)            pos_cnt <= pos_cnt + 1'b1;
    end

    // Falling-edge count: one ahead of the rising-edge count
    always_ff @(negedge clk or negedge rst_in_n) begin
        if (!rst_in_n)                        neg_cnt <= '0;
        else if (!core_rst_n)                 neg_cnt <= '0;
        else if (neg_cnt < NEGMAX)            neg_cnt <= pos_cnt + 1'b1;
    end

    // Strobe launched on the falling edge that completes the count
    always_ff @(negedge clk or negedge rst_in_n) begin
        if (!rst_in_n) go <= 1'b0;
        else           go <= core_rst_n && (pos_cnt == FULL_P) && (neg_cnt == FULL_P);
    end

    assign half = HW'(pos_cnt) + HW'(neg_cnt);

    AST_GO_SINGLE_PERIOD: assert property (@(posedge clk) disable iff (!rst_in_n)
        go |=> !go); // R4
    AST_GO_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_in_n)
        go |-> (half == TERM)); // R3
    AST_HALF_BOUNDED: assert property (@(posedge clk) disable iff (!rst_in_n)
        half <= TERM); // R3
    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_in_n)
        !core_rst_n |-> (!go && half == '0)); // R1

endmodule

// File: rtl/boot_reset_strap.sv
// Address-mode strap latch.
// Does: reads the strap on the first rising edge after core release and
// holds it until the next board reset; reads high before capture.
// Assumes: strap input is static around the capture edge.
module boot_reset_strap (
    input  logic clk,
    input  logic rst_in_n,
    input  logic core_rst_n,
    input  logic strap_in,
    output logic strap_q
);

    logic taken;

    // One-shot capture of the strap after release
    always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n) begin
            strap_q <= 1'b1;
            taken   <= 1'b0;
        end else if (core_rst_n && !taken) begin
            strap_q <= strap_in;
            taken   <= 1'b1;
        end
    end

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_in_n)
        taken |=> $stable(strap_q)); // R7

endmodule

// File: rtl/boot_reset_region.sv
// Address-phase omit decode.
// Does: for upper and lower region cycles, passes the region's
// disable-address bit when the latched strap allows it; 0 otherwise.
// Assumes: control bytes are stable during the bus cycle.
module boot_reset_region
    import boot_reset_pkg::*;
(
    input  logic             clk,
    input  logic             rst_in_n,
    input  logic             strap_q,
    input  logic [1:0]       region_sel,
    input  logic [CTL_W-1:0] upper_ctl,
    input  logic [CTL_W-1:0] lower_ctl,
    output logic             addr_omit
);

    region_e rgn;
    logic    dis_bit;

    // Pick the disable-address bit of the selected region
    always_comb begin
        rgn = region_e'(region_sel);
        unique case (rgn)
            RGN_UPPER: dis_bit = upper_ctl[DIS_BIT];
            RGN_LOWER: dis_bit = lower_ctl[DIS_BIT];
            default:   dis_bit = 1'b0;
        endcase
    end

    assign addr_omit = strap_q & dis_bit;

    AST_LOW_STRAP_NO_OMIT: assert property (@(posedge clk) disable iff (!rst_in_n)
        !strap_q |-> !addr_omit); // R9
    AST_OTHER_REGION_NO_OMIT: assert property (@(posedge clk) disable iff (!rst_in_n)
        (region_sel == 2'b00 || region_sel == 2'b11) |-> !addr_omit); // R10

endmodule

// File: rtl/boot_reset_seq.sv
// Boot reset sequencer top.
// Does: synchronizes the board reset, times the first fetch in
// half-period steps, latches the address-mode strap and decodes the
// address-phase omit flag.
// Assumes: one clock domain; board reset asynchronous.
module boot_reset_seq
    import boot_reset_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FETCH_FULL  = 6,
    localparam int unsigned HW = $clog2(2 * FETCH_FULL + 2)
) (
    input  logic              clk,
    input  logic              rst_in_n,
    input  logic              strap_in,
    input  logic [1:0]        region_sel,
    input  logic [CTL_W-1:0]  upper_ctl,
    input  logic [CTL_W-1:0]  lower_ctl,
    output logic              core_rst_n,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [HW-1:0]     seq_half,
    output logic              strap_q,
    output logic              addr_omit
);

    boot_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_in_n   (rst_in_n),
        .core_rst_n (core_rst_n)
    );

    boot_reset_timer #(.FULL(FETCH_FULL)) u_timer (
        .clk        (clk),
        .rst_in_n   (rst_in_n),
        .core_rst_n (core_rst_n),
        .go         (fetch_go),
        .half       (seq_half)
    );

    boot_reset_strap u_strap (
        .clk        (clk),
        .rst_in_n   (rst_in_n),
        .core_rst_n (core_rst_n),
        .strap_in   (strap_in),
        .strap_q    (strap_q)
    );

    boot_reset_region u_region (
        .clk        (clk),
        .rst_in_n   (rst_in_n),
        .strap_q    (strap_q),
        .region_sel (region_sel),
        .upper_ctl  (upper_ctl),
        .lower_ctl  (lower_ctl),
        .addr_omit  (addr_omit)
    );

    // Restart address is presented only alongside the strobe
    assign fetch_addr = fetch_go ? RESTART_VEC : '0;

endmodule

// File: tb/boot_reset_seq_bench.sv
`timescale 1ns/1ps
module boot_reset_seq_bench;

    logic       clk = 1'b0;
    logic       rst_in_n = 1'b0;
    logic       strap_in = 1'b1;
    logic [1:0] region_sel = 2'b00;
    logic [7:0] upper_ctl = 8'h00;
    logic [7:0] lower_ctl = 8'h00;
    logic        core_rst_n, fetch_go, strap_q, addr_omit;
    logic [19:0] fetch_addr;
    logic [3:0]  seq_half;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // reference model state
    int  m_sync1 = 0, m_sync2 = 0, m_half = 0, m_go = 0, m_strap = 1, m_taken = 0;
    int  m_gocount = 0;

    always #10 clk = ~clk;

    boot_reset_seq u_boot_reset_seq (
        .clk(clk), .rst_in_n(rst_in_n), .strap_in(strap_in),
        .region_sel(region_sel), .upper_ctl(upper_ctl), .lower_ctl(lower_ctl),
        .core_rst_n(core_rst_n), .fetch_go(fetch_go), .fetch_addr(fetch_addr),
        .seq_half(seq_half), .strap_q(strap_q), .addr_omit(addr_omit)
    );

    task automatic model_clear();
        m_sync1 = 0; m_sync2 = 0; m_half = 0; m_go = 0; m_strap = 1; m_taken = 0;
        m_gocount = 0;
    endtask

    always @(negedge rst_in_n) model_clear();

    // model: rising edge
    always @(posedge clk) begin
        if (!rst_in_n) model_clear();
        else begin
            if (m_sync2 == 1) begin
                if (m_half < 13) m_half++;
                if (m_taken == 0) begin m_strap = strap_in; m_taken = 1; end
            end
            m_sync2 = m_sync1;
            m_sync1 = 1;
        end
    end

    // model: falling edge
    always @(negedge clk) begin
        if (rst_in_n && m_sync2 == 1) begin
            if (m_half == 12) begin m_half = 13; m_go = 1; m_gocount++; end
            else begin
                m_go = 0;
                if (m_half < 13) m_half++;
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        int omit_e;
        omit_e = 0;
        if (m_strap == 1) begin
            if (region_sel == 2'b01) omit_e = lower_ctl[7];
            else if (region_sel == 2'b10) omit_e = upper_ctl[7];
        end
        chk({31'd0, core_rst_n}, m_sync2, "R1/R2 core_rst_n");
        chk({28'd0, seq_half}, m_half, "R3/R6 seq_half");
        chk({31'd0, fetch_go}, m_go, "R4 fetch_go");
        chk({12'd0, fetch_addr}, (m_go == 1) ? 32'hFFFF0 : 32'h0, "R5 fetch_addr");
        chk({31'd0, strap_q}, m_strap, "R7 strap_q");
        if (m_strap == 0)
            chk({31'd0, addr_omit}, 0, "R9 addr_omit strap low");
        else if (region_sel == 2'b00 || region_sel == 2'b11)
            chk({31'd0, addr_omit}, 0, "R10 addr_omit no region");
        else
            chk({31'd0, addr_omit}, omit_e, "R8 addr_omit region bit");
        if (m_gocount > 1) chk(m_gocount, 1, "R4 single pulse");
    endtask

    always @(posedge clk) begin #5; if (!done) compare_all(); end
    always @(negedge clk) begin #5; if (!done) compare_all(); end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic sweep(input int n);
        for (int i = 0; i < n; i++) begin
            region_sel = 2'(i);
            upper_ctl  = (i[2]) ? 8'h80 : 8'h7F;
            lower_ctl  = (i[3]) ? 8'h80 : 8'h7F;
            cyc(1);
        end
    endtask

    initial begin
        // R1: held in reset, async assertion
        cyc(3);
        chk({31'd0, core_rst_n}, 0, "R1 reset state");
        chk({31'd0, strap_q}, 1, "R1 strap default");
        rst_in_n = 1'b1;                 // release, strap high
        cyc(4);
        strap_in = 1'b0;                 // R7: ignored after capture
        sweep(20);
        chk({31'd0, strap_q}, 1, "R7 strap held high");
        // R1: assert mid-cycle, check before any edge
        @(negedge clk); #1;
        rst_in_n = 1'b0; #1;
        chk({31'd0, core_rst_n}, 0, "R1 async assertion");
        chk({28'd0, seq_half}, 0, "R1 counter cleared");
        cyc(2);
        rst_in_n = 1'b1;                 // strap low this time
        cyc(5);
        rst_in_n = 1'b0;                 // R6: abort countdown
        #1 chk({28'd0, seq_half}, 0, "R6 abort clears count");
        cyc(2);
        strap_in = 1'b1;
        rst_in_n = 1'b1;
        cyc(4);
        sweep(16);
        rst_in_n = 1'b0;
        strap_in = 1'b0;
        cyc(2);
        rst_in_n = 1'b1;
        cyc(3);
        strap_in = 1'b1;                 // R7: ignored, strap_q stays 0
        sweep(16);
        chk({31'd0, strap_q}, 0, "R7 strap held low");
        cyc(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule